// File: doc/BRIEF.md
# Synchronization Code Sequence Generator

This block emits a continuous stream of 10-bit special code groups that a receiver can lock onto and use to mark timing epochs. Each frame opens with an alignment code (K28.3), carries one of six fixed fill patterns made of comma codes (K28.5) and skip codes (K28.0), and closes with another alignment code. A pass is a programmable number of frames. When a pass ends, the next one starts at once, and a one-cycle flag marks the boundary between them.

Running disparity is tracked across every code group. The alignment and comma codes carry an unbalanced bit count and flip the disparity. The skip code is balanced and leaves it alone. Disparity starts positive after reset, so across the whole stream comma groups sent in the comma-positive form are never outnumbered by those sent in the comma-negative form. An optional 7-bit whitener can scramble the code bits in serial order, using one of two feedback polynomials.

Top module: `sync_seq_gen`

## Requirements
- R1: A frame is an alignment code, then a fill, then an alignment code. Select values 0 to 5 pick the fills K, R, KR, KRRK, KRRKKR and KRRKKRRK, which give frames of 3, 3, 4, 6, 8 and 10 code groups.
- R2: Select values 6 and 7 pick the same fill as value 5 (KRRKKRRK).
- R3: Code bit 9 is the first serial bit. With running disparity negative, A = 0011110011, K = 0011111010 and R = 0011110100. With running disparity positive, each code is the bitwise complement. Disparity is positive after reset, each A or K flips it, and R leaves it unchanged.
- R4: With whitening off, the count of K groups sent as 0011111010 is never less than the count sent as 1100000101, and exceeds it by at most one.
- R5: `frame_start_o` is high exactly in the output cycles that carry a frame's opening alignment code, and never while `valid_o` is low.
- R6: A pass holds `rpt_cnt` frames, and a count of 0 is treated as 1. `pass_done_o` is high for one cycle, in the cycle after the closing alignment code of a pass's last frame appears. The next pass follows without a gap.
- R7: `pat_sel` is sampled only when a frame's opening alignment code is generated. `rpt_cnt` is sampled only when a pass's first opening code is generated. Changes at any other time have no effect on the frame or pass already in progress.
- R8: Outputs are zero after reset. Each clock edge that samples `en` high produces one code group on the following cycle with `valid_o` high. When `en` is low, `valid_o` and `frame_start_o` go low, `code_o` holds its last value, and sequence position, disparity and whitener state do not advance.
- R9: With `whiten_en` high, the 10 code bits, starting at bit 9, are XORed with 10 successive outputs of a 7-bit shift register. Each step outputs bit 6 and then shifts left, taking in bit6^bit5 when `poly_sel`=0 (x^7+x^6+1) or bit6^bit2 when `poly_sel`=1 (x^7+x^3+1). The register steps only for whitened code groups and is loaded with a nonzero seed at reset.
- R10: With `whiten_en` low, `code_o` carries the unscrambled code group, including after a period of whitening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the sequence and emit one code group |
| pat_sel | input | 3 | Fill pattern select |
| rpt_cnt | input | RPT_W | Frames per pass (0 treated as 1) |
| whiten_en | input | 1 | Apply the whitener to the emitted group |
| poly_sel | input | 1 | Whitener polynomial: 0 = x^7+x^6+1, 1 = x^7+x^3+1 |
| code_o | output | 10 | Code group, bit 9 first on the line |
| valid_o | output | 1 | `code_o` holds a new group this cycle |
| frame_start_o | output | 1 | Current group is a frame's opening alignment code |
| pass_done_o | output | 1 | One-cycle pulse after a pass's final group |

## Verification
A code group, its valid strobe and its frame-start flag are due one clock after the rising edge that samples `en` high. The pass-complete pulse is due one clock after that group, two clocks after its sampling edge. The bench drives inputs on the falling edge and steps its reference model once per stimulus, using the inputs the next rising edge will see. It compares every output at the following falling edge, so each result is checked in the exact cycle it is due. The inputs are changed in mid-frame and `en` is left low for stretches, so frame-boundary sampling and state holding are both checked against that timing.

// File: rtl/sync_seq_pkg.sv
package sync_seq_pkg;

   localparam int CODE_W    = 10;
   localparam int PAT_W     = 3;
   localparam int NUM_PAT   = 6;
   localparam int MAX_FILL  = 8;
   localparam int MAX_LEN   = MAX_FILL + 2;
   localparam int IDX_W     = $clog2(MAX_LEN);
   localparam int LFSR_W    = 7;
   localparam int POLY0_TAP = 6;
   localparam int POLY1_TAP = 3;

   localparam logic [CODE_W-1:0] CODE_A_NEG = 10'b0011110011;
   localparam logic [CODE_W-1:0] CODE_K_NEG = 10'b0011111010;
   localparam logic [CODE_W-1:0] CODE_R_NEG = 10'b0011110100;

   typedef enum logic [1:0] {
      SYM_A = 2'd0,
      SYM_K = 2'd1,
      SYM_R = 2'd2
   } sym_e;

   // out-of-range selects fall back to the longest fill
   function automatic logic [PAT_W-1:0] pat_clamp(input logic [PAT_W-1:0] s);
      return (s > PAT_W'(NUM_PAT - 1)) ? PAT_W'(NUM_PAT - 1) : s;
   endfunction

   function automatic logic [IDX_W-1:0] frame_len(input logic [PAT_W-1:0] p);
      logic [IDX_W-1:0] fill;
      case (p)
         3'd0, 3'd1: fill = IDX_W'(1);
         3'd2:       fill = IDX_W'(2);
         3'd3:       fill = IDX_W'(4);
         3'd4:       fill = IDX_W'(6);
         default:    fill = IDX_W'(MAX_FILL);
      endcase
      return fill + IDX_W'(2);
   endfunction

   // all fills except select 1 are prefixes of K R R K K R R K
   function automatic sym_e fill_sym(input logic [PAT_W-1:0] p,
                                     input logic [IDX_W-1:0] j);
      if (p == 3'd1)
         return SYM_R;
      return (j[1:0] == 2'd0 || j[1:0] == 2'd3) ? SYM_K : SYM_R;
   endfunction

   function automatic logic [CODE_W-1:0] neg_code(input sym_e s);
      case (s)
         SYM_K:   return CODE_K_NEG;
         SYM_R:   return CODE_R_NEG;
         default: return CODE_A_NEG;
      endcase
   endfunction

endpackage

// File: rtl/ssg_sequencer.sv
module ssg_sequencer
   import sync_seq_pkg::*;
#(
   parameter int RPT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PAT_W-1:0] pat_sel,
   input  logic [RPT_W-1:0] rpt_cnt,
   output sym_e             sym_o,
   output logic             frame_first_o,
   output logic             pass_last_o
);

   logic [IDX_W-1:0] idx_q;
   logic [RPT_W-1:0] frm_q;
   logic [RPT_W-1:0] rpt_q;
   logic [PAT_W-1:0] pat_q;

   logic             at_start;
   logic             pass_start;
   logic             at_end;
   logic [PAT_W-1:0] pat_cur;
   logic [RPT_W-1:0] rpt_cur;
   logic [IDX_W-1:0] len_cur;

   always_comb begin
      at_start   = (idx_q == '0);
      pass_start = at_start && (frm_q == '0);
      pat_cur    = at_start ? pat_clamp(pat_sel) : pat_q;
      if (pass_start)
         rpt_cur = (rpt_cnt == '0) ? RPT_W'(1) : rpt_cnt;
      else
         rpt_cur = rpt_q;
      len_cur = frame_len(pat_cur);
      at_end  = (idx_q == len_cur - IDX_W'(1));
      if (at_start || at_end)
         sym_o = SYM_A;
      else
         sym_o = fill_sym(pat_cur, idx_q - IDX_W'(1));
      frame_first_o = at_start;
      pass_last_o   = at_end && (frm_q == rpt_cur - RPT_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         frm_q <= '0;
         rpt_q <= RPT_W'(1);
         pat_q <= '0;
      end else if (en) begin
         if (at_start)
            pat_q <= pat_cur;
         if (pass_start)
            rpt_q <= rpt_cur;
         if (at_end) begin
            idx_q <= '0;
            frm_q <= pass_last_o ? '0 : frm_q + RPT_W'(1);
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

endmodule

// File: rtl/ssg_disp_enc.sv
module ssg_disp_enc
   import sync_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  sym_e              sym_i,
   output logic [CODE_W-1:0] code_o
);

   logic              rd_pos_q;
   logic [CODE_W-1:0] base;

   always_comb begin
      base   = neg_code(sym_i);
      code_o = rd_pos_q ? ~base : base;
   end

   // positive start makes the first comma group use the comma-positive form
   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_pos_q <= 1'b1;
      else if (en && sym_i != SYM_R)
         rd_pos_q <= ~rd_pos_q;
   end

endmodule

// File: rtl/ssg_whitener.sv
module ssg_whitener
   import sync_seq_pkg::*;
#(
   parameter logic [LFSR_W-1:0] SEED = 7'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              whiten_en,
   input  logic              poly_sel,
   input  logic [CODE_W-1:0] data_i,
   output logic [CODE_W-1:0] data_o
);

   if (POLY0_TAP < 1 || POLY0_TAP >= LFSR_W) begin : g_bad_tap0
      $error("ssg_whitener: first polynomial tap out of range");
   end
   if (POLY1_TAP < 1 || POLY1_TAP >= LFSR_W) begin : g_bad_tap1
      $error("ssg_whitener: second polynomial tap out of range");
   end

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] chain [0:CODE_W];
   logic [CODE_W-1:0] mask;

   assign chain[0] = state_q;

   // one register step per serial bit, bit CODE_W-1 first
   for (genvar i = 0; i < CODE_W; i++) begin : g_step
      logic fb;
      assign mask[CODE_W-1-i] = chain[i][LFSR_W-1];
      assign fb = chain[i][LFSR_W-1] ^
                  (poly_sel ? chain[i][POLY1_TAP-1] : chain[i][POLY0_TAP-1]);
      assign chain[i+1] = {chain[i][LFSR_W-2:0], fb};
   end

   assign data_o = whiten_en ? (data_i ^ mask) : data_i;

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= SEED;
      else if (en && whiten_en)
         state_q <= chain[CODE_W];
   end

endmodule

// File: rtl/sync_seq_gen.sv
module sync_seq_gen
   import sync_seq_pkg::*;
#(
   parameter int                RPT_W     = 8,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 7'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PAT_W-1:0]  pat_sel,
   input  logic [RPT_W-1:0]  rpt_cnt,
   input  logic              whiten_en,
   input  logic              poly_sel,
   output logic [CODE_W-1:0] code_o,
   output logic              valid_o,
   output logic              frame_start_o,
   output logic              pass_done_o
);

   if (RPT_W < 1 || RPT_W > 16) begin : g_bad_rpt_w
      $error("sync_seq_gen: RPT_W must lie in 1..16");
   end
   if (LFSR_SEED == '0) begin : g_bad_seed
      $error("sync_seq_gen: whitener seed must be nonzero");
   end

   sym_e              sym;
   logic              frame_first;
   logic              pass_last;
   logic [CODE_W-1:0] code_raw;
   logic [CODE_W-1:0] code_next;
   logic              last_q;

   ssg_sequencer #(.RPT_W(RPT_W)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .pat_sel      (pat_sel),
      .rpt_cnt      (rpt_cnt),
      .sym_o        (sym),
      .frame_first_o(frame_first),
      .pass_last_o  (pass_last)
   );

   ssg_disp_enc i_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .sym_i (sym),
      .code_o(code_raw)
   );

   ssg_whitener #(.SEED(LFSR_SEED)) i_wht (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .whiten_en(whiten_en),
      .poly_sel (poly_sel),
      .data_i   (code_raw),
      .data_o   (code_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_o        <= '0;
         valid_o       <= 1'b0;
         frame_start_o <= 1'b0;
         pass_done_o   <= 1'b0;
         last_q        <= 1'b0;
      end else begin
         pass_done_o <= last_q;
         if (en) begin
            code_o        <= code_next;
            valid_o       <= 1'b1;
            frame_start_o <= frame_first;
            last_q        <= pass_last;
         end else begin
            valid_o       <= 1'b0;
            frame_start_o <= 1'b0;
            last_q        <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ssg_checker.sv
module ssg_checker
   import sync_seq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              whiten_en,
   input logic              valid_o,
   input logic              frame_start_o,
   input logic              pass_done_o,
   input logic [CODE_W-1:0] code_o,
   input logic [CODE_W-1:0] code_raw
);

   logic signed [3:0] comma_bal;

   always_ff @(posedge clk) begin
      if (!rst_n)
         comma_bal <= 4'sd0;
      else if (en && code_raw == CODE_K_NEG)
         comma_bal <= comma_bal + 4'sd1;
      else if (en && code_raw == ~CODE_K_NEG)
         comma_bal <= comma_bal - 4'sd1;
   end

   AST_COMMA_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (comma_bal == 4'sd0 || comma_bal == 4'sd1)) else $error("comma balance"); // R4

   AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |-> valid_o) else $error("start without valid"); // R5

   AST_START_IS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start_o && !$past(whiten_en)) |->
         (code_o == CODE_A_NEG || code_o == ~CODE_A_NEG)) else $error("start not A"); // R1

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done_o |=> !pass_done_o) else $error("done longer than one cycle"); // R6

   AST_DONE_AFTER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done_o |-> $past(valid_o)) else $error("done without final group"); // R6

   AST_IDLE_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(code_o)) else $error("code moved while idle"); // R8

endmodule

bind sync_seq_gen ssg_checker i_ssg_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (en),
   .whiten_en    (whiten_en),
   .valid_o      (valid_o),
   .frame_start_o(frame_start_o),
   .pass_done_o  (pass_done_o),
   .code_o       (code_o),
   .code_raw     (code_raw)
);

// File: tb/test_sync_seq_gen.sv
module test_sync_seq_gen;

   localparam int         RPT_W = 8;
   localparam logic [6:0] SEED  = 7'h5A;
   localparam logic [9:0] A_N   = 10'b0011110011;
   localparam logic [9:0] K_N   = 10'b0011111010;
   localparam logic [9:0] R_N   = 10'b0011110100;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [2:0]       pat_sel = 3'd0;
   logic [RPT_W-1:0] rpt_cnt = 8'd1;
   logic             whiten_en = 1'b0;
   logic             poly_sel = 1'b0;
   logic [9:0]       code_o;
   logic             valid_o;
   logic             frame_start_o;
   logic             pass_done_o;

   sync_seq_gen #(.RPT_W(RPT_W), .LFSR_SEED(SEED)) i_sync_seq_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .pat_sel      (pat_sel),
      .rpt_cnt      (rpt_cnt),
      .whiten_en    (whiten_en),
      .poly_sel     (poly_sel),
      .code_o       (code_o),
      .valid_o      (valid_o),
      .frame_start_o(frame_start_o),
      .pass_done_o  (pass_done_o)
   );

   always #10 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   string ctx = "R3";
   bit    track_comma = 1'b1;
   int    kpos = 0;
   int    kneg = 0;

   int         m_idx, m_frm, m_pat, m_rpt;
   bit         m_rd_pos, m_last;
   logic [6:0] m_lfsr;
   logic [9:0] exp_code;
   bit         exp_valid, exp_fs, exp_pd, exp_wht;

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic string fill_of(int p);
      case (p)
         0:       return "K";
         1:       return "R";
         2:       return "KR";
         3:       return "KRRK";
         4:       return "KRRKKR";
         default: return "KRRKKRRK";
      endcase
   endfunction

   function automatic logic [9:0] base_of(byte ch);
      if (ch == "K") return K_N;
      if (ch == "R") return R_N;
      return A_N;
   endfunction

   task automatic model_reset();
      m_idx = 0; m_frm = 0; m_pat = 0; m_rpt = 1;
      m_rd_pos = 1'b1; m_last = 1'b0; m_lfsr = SEED;
      exp_code = '0; exp_valid = 0; exp_fs = 0; exp_pd = 0; exp_wht = 0;
      kpos = 0; kneg = 0;
   endtask

   // R8: reset clears the outputs
   task automatic do_reset();
      rst_n = 1'b0; en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      check("R8", "reset code", int'(code_o), 0);
      check("R8", "reset valid", int'(valid_o), 0);
      check("R8", "reset start", int'(frame_start_o), 0);
      check("R8", "reset done", int'(pass_done_o), 0);
   endtask

   // one stimulus cycle: model step, clock edge, compare at falling edge
   task automatic step();
      string      fr;
      byte        ch;
      int         p;
      logic [9:0] c;
      bit         fb;
      exp_pd = m_last;
      if (en) begin
         p = (m_idx == 0) ? ((pat_sel > 3'd5) ? 5 : int'(pat_sel)) : m_pat;
         if (m_idx == 0) m_pat = p;
         if (m_idx == 0 && m_frm == 0) m_rpt = (rpt_cnt == 0) ? 1 : int'(rpt_cnt);
         fr = {"A", fill_of(p), "A"};
         ch = fr[m_idx];
         c = base_of(ch);
         if (m_rd_pos) c = ~c;
         if (ch != "R") m_rd_pos = !m_rd_pos;
         exp_wht = whiten_en;
         if (whiten_en) begin
            for (int i = 9; i >= 0; i--) begin
               c[i] = c[i] ^ m_lfsr[6];
               fb = poly_sel ? (m_lfsr[6] ^ m_lfsr[2]) : (m_lfsr[6] ^ m_lfsr[5]);
               m_lfsr = {m_lfsr[5:0], fb};
            end
         end
         exp_code  = c;
         exp_valid = 1;
         exp_fs    = (m_idx == 0);
         m_last    = (m_idx == fr.len() - 1) && (m_frm == m_rpt - 1);
         if (m_idx == fr.len() - 1) begin
            m_idx = 0;
            m_frm = m_last ? 0 : m_frm + 1;
         end else begin
            m_idx++;
         end
      end else begin
         exp_valid = 0; exp_fs = 0; m_last = 0;
      end
      @(posedge clk);
      @(negedge clk);
      check("R8", "valid", int'(valid_o), int'(exp_valid));
      check("R5", "frame start", int'(frame_start_o), int'(exp_fs));
      check("R6", "pass done", int'(pass_done_o), int'(exp_pd));
      check(exp_valid ? ctx : "R8", "code", int'(code_o), int'(exp_code));
      if (track_comma && exp_valid && !exp_wht &&
          (code_o == K_N || code_o == ~K_N)) begin
         if (code_o == K_N) kpos++; else kneg++;
         check("R4", "comma-positive count not below comma-negative",
               int'(kpos >= kneg && kpos <= kneg + 1), 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog expired: cycles=200000 expected fewer");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240517));
      do_reset();

      // R1: every fill pattern, two frames per pass
      ctx = "R1"; en = 1'b1; rpt_cnt = 8'd2;
      for (int p = 0; p < 6; p++) begin
         pat_sel = 3'(p);
         repeat (24) step();
      end

      // R2: out-of-range selects
      ctx = "R2";
      pat_sel = 3'd6; repeat (25) step();
      pat_sel = 3'd7; repeat (25) step();

      // R6: zero count and a long pass
      ctx = "R6";
      pat_sel = 3'd0; rpt_cnt = 8'd0; repeat (12) step();
      pat_sel = 3'd3; rpt_cnt = 8'd8; repeat (70) step();

      // R7: inputs changed on every cycle, mid-frame
      ctx = "R7";
      for (int i = 0; i < 200; i++) begin
         pat_sel = 3'($urandom);
         rpt_cnt = 8'($urandom % 4);
         step();
      end

      // R8: enable gaps
      ctx = "R8";
      for (int i = 0; i < 200; i++) begin
         en = ($urandom % 2) == 0;
         if ($urandom % 8 == 0) pat_sel = 3'($urandom);
         step();
      end

      // R9: whitening with each polynomial from a fresh seed
      do_reset();
      track_comma = 1'b0;
      ctx = "R9"; en = 1'b1; whiten_en = 1'b1; pat_sel = 3'd4; rpt_cnt = 8'd3;
      poly_sel = 1'b0; repeat (100) step();
      poly_sel = 1'b1; repeat (100) step();

      // R10: raw codes after whitening
      ctx = "R10"; whiten_en = 1'b0; repeat (50) step();

      // R3: constrained random mix
      ctx = "R3";
      for (int i = 0; i < 3000; i++) begin
         en = ($urandom % 8) != 0;
         if ($urandom % 16 == 0) pat_sel = 3'($urandom);
         rpt_cnt = 8'($urandom % 5);
         if ($urandom % 64 == 0) whiten_en = ~whiten_en;
         if ($urandom % 32 == 0) poly_sel = ~poly_sel;
         step();
      end

      finish_run();
   end

endmodule